// File: doc/BRIEF.md
# Firmware Segment Padding Loader

This block writes one program segment of a small embedded core's firmware image into that core's local memories. A segment descriptor is presented together with a one-cycle start strobe: a flag saying whether the segment holds executable code, its load address counted in 32-bit words, the segment's offset within the image, the number of bytes present in the image (file size), the number of bytes it occupies once loaded (memory size), and the total image size. The segment payload then arrives as a byte stream under a valid/ready handshake.

Code segments are routed to instruction memory. Each instruction is three bytes wide in the image but occupies a 32-bit slot in memory, so a zero byte is inserted after every third source byte. All other segments are routed to data memory. Their bytes are copied unchanged and the tail up to the memory size is cleared. Before anything is written, a segment that would extend beyond the end of the image is refused and flagged. The output is a byte-wide write port carrying a strobe, a memory select, a byte address and a data byte. A host sequencer calls the block once per loadable segment.

Top module: `fwl_loader`

## Requirements
- R1: With `seg_exec`=1, every write of the segment has `wr_imem`=1. With `seg_exec`=0, every write has `wr_imem`=0.
- R2: For a code segment, a zero byte is written after each third accepted byte, so 3 input bytes fill 4 consecutive addresses. Every write at a byte address whose two low bits are 2'b11 therefore carries 0. When the file size is not a multiple of 3, no pad byte follows the final partial group.
- R3: The first write of a segment goes to byte address `{seg_load_addr[19:0], 2'b00}`. Bits 31..20 of the load address have no effect.
- R4: For a data segment, the accepted bytes are written unchanged. When the memory size exceeds the file size, zero bytes follow until memory-size bytes have been written in total. When it does not, no zero bytes are written.
- R5: If `seg_offset + seg_file_size > image_size` (compared without overflow), `seg_error` is 1 from the cycle after the start, no write occurs, no done pulse occurs and no byte is accepted. A segment whose end equals the image size is accepted. The next accepted start clears `seg_error`.
- R6: Consecutive writes of a segment go to consecutive byte addresses, each one greater than the last. Pad and fill bytes are included.
- R7: `seg_done` is a one-cycle pulse. It coincides with the final write of a segment. A segment that produces no writes pulses it in the cycle after the start. It pulses exactly once per accepted segment.
- R8: `in_ready` is 0 out of reset, while idle, and in every cycle that emits a pad or fill byte. Input bytes are accepted only on cycles where both `in_valid` and `in_ready` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_start | input | 1 | One-cycle strobe that latches the descriptor; taken only when idle |
| seg_exec | input | 1 | 1 = code segment (instruction memory), 0 = data segment |
| seg_load_addr | input | 32 | Load address in 32-bit words; low 20 bits used |
| seg_offset | input | 32 | Segment offset within the image, in bytes |
| seg_file_size | input | 32 | Bytes of the segment present in the image |
| seg_mem_size | input | 32 | Bytes the segment occupies in memory (data segments) |
| image_size | input | 32 | Total image size in bytes |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| wr_en | output | 1 | Memory byte write strobe |
| wr_imem | output | 1 | 1 = instruction memory, 0 = data memory |
| wr_addr | output | 22 | Byte address of the write |
| wr_data | output | 8 | Byte to write |
| seg_done | output | 1 | Pulse on the last write of a segment |
| seg_error | output | 1 | Segment refused for exceeding the image |

## Verification
The checks inside the design assume three things about the inputs. A start is issued only once the previous segment has signalled done or error, and never in the cycle right after a done pulse. The stream delivers exactly file-size bytes per segment. `in_data` is held while `in_valid` is high and `in_ready` is low. The bench follows this by waiting for completion plus a few idle cycles before each new descriptor and by holding the byte steady through pad stalls. It mixes continuous and gapped `in_valid` so that pad stalls and source idles both occur, and it drives load addresses with nonzero upper bits.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_COPY = 2'd1,
    ST_PAD  = 2'd2,
    ST_FILL = 2'd3
  } fwl_state_e;
endpackage

// File: rtl/fwl_range_check.sv
module fwl_range_check #(
  parameter int SIZE_W = 32
) (
  input  logic [SIZE_W-1:0] offset,
  input  logic [SIZE_W-1:0] file_size,
  input  logic [SIZE_W-1:0] image_size,
  output logic              out_of_range
);
  localparam int SUM_W = SIZE_W + 1;
  logic [SUM_W-1:0] seg_end;

  always_comb begin
    seg_end      = {1'b0, offset} + {1'b0, file_size};
    out_of_range = seg_end > {1'b0, image_size};
  end
endmodule

// File: rtl/fwl_seq.sv
module fwl_seq
  import fwl_pkg::*;
#(
  parameter int SIZE_W     = 32,
  parameter int DATA_W     = 8,
  parameter int LOAD_BITS  = 20,
  parameter int INSN_BYTES = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      seg_start,
  input  logic                      seg_exec,
  input  logic [SIZE_W-1:0]         seg_load_addr,
  input  logic [SIZE_W-1:0]         seg_file_size,
  input  logic [SIZE_W-1:0]         seg_mem_size,
  input  logic                      range_bad,
  input  logic                      in_valid,
  input  logic [DATA_W-1:0]         in_data,
  output logic                      in_ready,
  output logic                      req_we,
  output logic                      req_imem,
  output logic [LOAD_BITS+1:0]      req_addr,
  output logic [DATA_W-1:0]         req_data,
  output logic                      req_done,
  output logic                      seg_error
);
  localparam int BADDR_W = LOAD_BITS + 2;
  localparam int GRP_W   = $clog2(INSN_BYTES);
  localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(INSN_BYTES - 1);

  fwl_state_e          state;
  logic                is_exec;
  logic [BADDR_W-1:0]  addr_cnt;
  logic [SIZE_W-1:0]   copy_left;
  logic [SIZE_W-1:0]   fill_left;
  logic [GRP_W-1:0]    grp_cnt;

  logic                take;
  logic                last_copy;
  logic                grp_end;
  logic                start_ok;
  logic [SIZE_W-1:0]   fill_len;
  logic [BADDR_W-1:0]  base_addr;

  always_comb begin
    in_ready  = (state == ST_COPY);
    take      = in_ready && in_valid;
    last_copy = (copy_left == SIZE_W'(1));
    grp_end   = is_exec && (grp_cnt == GRP_LAST);
    start_ok  = (state == ST_IDLE) && seg_start && !range_bad;
    base_addr = {seg_load_addr[LOAD_BITS-1:0], 2'b00};
    if (!seg_exec && (seg_mem_size > seg_file_size))
      fill_len = seg_mem_size - seg_file_size;
    else
      fill_len = '0;
  end

  always_comb begin
    req_we   = 1'b0;
    req_data = '0;
    req_done = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start_ok && (seg_file_size == '0) && (fill_len == '0))
          req_done = 1'b1;
      end
      ST_COPY: begin
        if (take) begin
          req_we   = 1'b1;
          req_data = in_data;
          req_done = last_copy && !grp_end && (fill_left == '0);
        end
      end
      ST_PAD: begin
        req_we   = 1'b1;
        req_done = (copy_left == '0);
      end
      ST_FILL: begin
        req_we   = 1'b1;
        req_done = (fill_left == SIZE_W'(1));
      end
      default: ;
    endcase
    req_addr = addr_cnt;
    req_imem = is_exec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      is_exec   <= 1'b0;
      addr_cnt  <= '0;
      copy_left <= '0;
      fill_left <= '0;
      grp_cnt   <= '0;
      seg_error <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (seg_start) begin
            seg_error <= range_bad;
            if (!range_bad) begin
              is_exec   <= seg_exec;
              addr_cnt  <= base_addr;
              copy_left <= seg_file_size;
              fill_left <= fill_len;
              grp_cnt   <= '0;
              if (seg_file_size != '0)
                state <= ST_COPY;
              else if (fill_len != '0)
                state <= ST_FILL;
            end
          end
        end
        ST_COPY: begin
          if (take) begin
            addr_cnt  <= addr_cnt + BADDR_W'(1);
            copy_left <= copy_left - SIZE_W'(1);
            grp_cnt   <= (grp_cnt == GRP_LAST) ? '0 : grp_cnt + GRP_W'(1);
            if (grp_end)
              state <= ST_PAD;
            else if (last_copy)
              state <= (fill_left != '0) ? ST_FILL : ST_IDLE;
          end
        end
        ST_PAD: begin
          addr_cnt <= addr_cnt + BADDR_W'(1);
          state    <= (copy_left == '0) ? ST_IDLE : ST_COPY;
        end
        ST_FILL: begin
          addr_cnt  <= addr_cnt + BADDR_W'(1);
          fill_left <= fill_left - SIZE_W'(1);
          if (fill_left == SIZE_W'(1))
            state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // a refused segment never writes and never takes input
  assert_refused_silent_R5: assert property (@(posedge clk) disable iff (rst)
    seg_error |-> (!req_we && !in_ready));

  // nonzero bytes only come from a completed input handshake
  assert_data_from_stream_R4: assert property (@(posedge clk) disable iff (rst)
    (req_we && (req_data != '0)) |-> (in_valid && in_ready));

  // pad and fill cycles stall the stream
  assert_stall_on_insert_R8: assert property (@(posedge clk) disable iff (rst)
    (req_we && !take) |-> !in_ready);
endmodule

// File: rtl/fwl_wr_port.sv
module fwl_wr_port #(
  parameter int BADDR_W = 22,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_we,
  input  logic               req_imem,
  input  logic [BADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]  req_data,
  input  logic               req_done,
  output logic               wr_en,
  output logic               wr_imem,
  output logic [BADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0]  wr_data,
  output logic               seg_done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en    <= 1'b0;
      wr_imem  <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      seg_done <= 1'b0;
    end else begin
      wr_en    <= req_we;
      seg_done <= req_done;
      if (req_we) begin
        wr_imem <= req_imem;
        wr_addr <= req_addr;
        wr_data <= req_data;
      end
    end
  end

  // every fourth slot of an instruction word is the zero pad
  assert_pad_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_imem && (wr_addr[1:0] == 2'b11)) |-> (wr_data == '0));

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en) && !$past(seg_done)) |-> (wr_addr == $past(wr_addr) + BADDR_W'(1)));

  assert_target_stable_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en) && !$past(seg_done)) |-> (wr_imem == $past(wr_imem)));
endmodule

// File: rtl/fwl_loader.sv
module fwl_loader #(
  parameter int SIZE_W     = 32,
  parameter int DATA_W     = 8,
  parameter int LOAD_BITS  = 20,
  parameter int INSN_BYTES = 3,
  localparam int BADDR_W   = LOAD_BITS + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               seg_start,
  input  logic               seg_exec,
  input  logic [SIZE_W-1:0]  seg_load_addr,
  input  logic [SIZE_W-1:0]  seg_offset,
  input  logic [SIZE_W-1:0]  seg_file_size,
  input  logic [SIZE_W-1:0]  seg_mem_size,
  input  logic [SIZE_W-1:0]  image_size,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  output logic               in_ready,
  output logic               wr_en,
  output logic               wr_imem,
  output logic [BADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0]  wr_data,
  output logic               seg_done,
  output logic               seg_error
);
  logic               range_bad;
  logic               req_we;
  logic               req_imem;
  logic [BADDR_W-1:0] req_addr;
  logic [DATA_W-1:0]  req_data;
  logic               req_done;

  fwl_range_check #(.SIZE_W(SIZE_W)) i_range (
    .offset       (seg_offset),
    .file_size    (seg_file_size),
    .image_size   (image_size),
    .out_of_range (range_bad)
  );

  fwl_seq #(
    .SIZE_W     (SIZE_W),
    .DATA_W     (DATA_W),
    .LOAD_BITS  (LOAD_BITS),
    .INSN_BYTES (INSN_BYTES)
  ) i_seq (
    .clk           (clk),
    .rst           (rst),
    .seg_start     (seg_start),
    .seg_exec      (seg_exec),
    .seg_load_addr (seg_load_addr),
    .seg_file_size (seg_file_size),
    .seg_mem_size  (seg_mem_size),
    .range_bad     (range_bad),
    .in_valid      (in_valid),
    .in_data       (in_data),
    .in_ready      (in_ready),
    .req_we        (req_we),
    .req_imem      (req_imem),
    .req_addr      (req_addr),
    .req_data      (req_data),
    .req_done      (req_done),
    .seg_error     (seg_error)
  );

  fwl_wr_port #(.BADDR_W(BADDR_W), .DATA_W(DATA_W)) i_wr (
    .clk      (clk),
    .rst      (rst),
    .req_we   (req_we),
    .req_imem (req_imem),
    .req_addr (req_addr),
    .req_data (req_data),
    .req_done (req_done),
    .wr_en    (wr_en),
    .wr_imem  (wr_imem),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .seg_done (seg_done)
  );

  // a done pulse never lasts two cycles while no new start was possible
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    (seg_done && !$past(seg_start)) |=> !seg_done);
endmodule

// File: tb/test_fwl_loader.sv
`timescale 1ns/1ps
module test_fwl_loader;
  typedef struct packed {
    logic        exec;
    logic [31:0] laddr;
    logic [15:0] offset;
    logic [7:0]  fsize;
    logic [7:0]  msize;
    logic [15:0] image;
    logic        gap;
  } seg_vec_t;

  localparam int NVEC = 9;
  localparam seg_vec_t VECS [NVEC] = '{
    '{1'b1, 32'h0000_0010, 16'd0,  8'd6,  8'd8,  16'd100, 1'b0},
    '{1'b1, 32'hFFF0_0005, 16'd4,  8'd7,  8'd0,  16'd100, 1'b1},
    '{1'b0, 32'h0000_0003, 16'd10, 8'd5,  8'd9,  16'd100, 1'b0},
    '{1'b0, 32'h0001_0000, 16'd20, 8'd6,  8'd4,  16'd100, 1'b1},
    '{1'b0, 32'h0000_0040, 16'd30, 8'd0,  8'd3,  16'd100, 1'b0},
    '{1'b1, 32'h0000_0050, 16'd30, 8'd0,  8'd0,  16'd100, 1'b0},
    '{1'b0, 32'h0000_0060, 16'd90, 8'd11, 8'd12, 16'd100, 1'b0},
    '{1'b1, 32'h0000_0070, 16'd95, 8'd5,  8'd0,  16'd100, 1'b0},
    '{1'b1, 32'h0000_0080, 16'd96, 8'd5,  8'd0,  16'd100, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        seg_start = 1'b0;
  logic        seg_exec = 1'b0;
  logic [31:0] seg_load_addr = '0;
  logic [31:0] seg_offset = '0;
  logic [31:0] seg_file_size = '0;
  logic [31:0] seg_mem_size = '0;
  logic [31:0] image_size = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        wr_en;
  logic        wr_imem;
  logic [21:0] wr_addr;
  logic [7:0]  wr_data;
  logic        seg_done;
  logic        seg_error;

  always #2.5 clk = ~clk;

  fwl_loader i_fwl_loader (
    .clk(clk), .rst(rst), .seg_start(seg_start), .seg_exec(seg_exec),
    .seg_load_addr(seg_load_addr), .seg_offset(seg_offset),
    .seg_file_size(seg_file_size), .seg_mem_size(seg_mem_size),
    .image_size(image_size), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .wr_en(wr_en), .wr_imem(wr_imem), .wr_addr(wr_addr),
    .wr_data(wr_data), .seg_done(seg_done), .seg_error(seg_error)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  int   obs_n;
  int   obs_addr [64];
  int   obs_data [64];
  logic obs_imem [64];
  int   done_cnt;
  logic done_with_wr;

  int   exp_n;
  int   exp_addr [64];
  int   exp_data [64];

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst && wr_en && obs_n < 64) begin
      obs_addr[obs_n] = int'(wr_addr);
      obs_data[obs_n] = int'(wr_data);
      obs_imem[obs_n] = wr_imem;
      obs_n++;
    end
    if (!rst && seg_done) begin
      done_cnt++;
      done_with_wr = wr_en;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] src_byte(input int v, input int i);
    return 8'h11 + 8'(v * 8) + 8'(i);
  endfunction

  task automatic build_expect(input int v);
    seg_vec_t s = VECS[v];
    int base = int'(s.laddr & 32'h000F_FFFF) * 4;
    int k = 0;
    for (int i = 0; i < int'(s.fsize); i++) begin
      exp_addr[k] = base + k; exp_data[k] = int'(src_byte(v, i)); k++;
      if (s.exec && (i % 3 == 2)) begin
        exp_addr[k] = base + k; exp_data[k] = 0; k++;
      end
    end
    if (!s.exec) begin
      for (int i = int'(s.fsize); i < int'(s.msize); i++) begin
        exp_addr[k] = base + k; exp_data[k] = 0; k++;
      end
    end
    exp_n = k;
  endtask

  task automatic run_seg(input int v);
    seg_vec_t s = VECS[v];
    logic exp_err = (int'(s.offset) + int'(s.fsize)) > int'(s.image);
    int i;
    logic acc;
    logic tog = 1'b0;
    build_expect(v);
    if (exp_err) exp_n = 0;
    obs_n = 0; done_cnt = 0; done_with_wr = 1'b0;
    @(negedge clk);
    seg_exec = s.exec; seg_load_addr = s.laddr; seg_offset = 32'(s.offset);
    seg_file_size = 32'(s.fsize); seg_mem_size = 32'(s.msize);
    image_size = 32'(s.image); seg_start = 1'b1;
    @(negedge clk);
    seg_start = 1'b0;
    chk(seg_error == exp_err, "R5 error flag after start", int'(seg_error), int'(exp_err));
    if (exp_err) chk(!in_ready, "R8 ready low when refused", int'(in_ready), 0);
    i = 0;
    while (!exp_err && i < int'(s.fsize)) begin
      tog = ~tog;
      if (s.gap && tog) in_valid = 1'b0;
      else begin in_valid = 1'b1; in_data = src_byte(v, i); end
      acc = in_valid && in_ready;
      @(negedge clk);
      if (acc) i++;
    end
    in_valid = 1'b0;
    for (int w = 0; w < 64 && done_cnt == 0 && !exp_err; w++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(obs_n == exp_n, exp_err ? "R5 no writes when refused" : (s.exec ? "R2 write count" : "R4 write count"), obs_n, exp_n);
    for (int j = 0; j < exp_n && j < obs_n; j++) begin
      chk(obs_addr[j] == exp_addr[j], (j == 0) ? "R3 base byte address" : "R6 address sequence", obs_addr[j], exp_addr[j]);
      chk(obs_data[j] == exp_data[j], s.exec ? "R2 instruction byte" : "R4 data byte", obs_data[j], exp_data[j]);
      chk(obs_imem[j] == s.exec, "R1 memory select", int'(obs_imem[j]), int'(s.exec));
    end
    chk(done_cnt == (exp_err ? 0 : 1), "R7 done pulse count", done_cnt, exp_err ? 0 : 1);
    if (!exp_err)
      chk(done_with_wr == (exp_n > 0), "R7 done aligned with last write", int'(done_with_wr), int'(exp_n > 0));
    chk(seg_error == exp_err, "R5 error held until next start", int'(seg_error), int'(exp_err));
  endtask

  initial begin
    obs_n = 0; done_cnt = 0; done_with_wr = 1'b0;
    repeat (3) @(negedge clk);
    chk(!in_ready, "R8 ready low in reset", int'(in_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!wr_en && !seg_done, "R7 idle outputs after reset", int'({wr_en, seg_done}), 0);
    chk(!seg_error, "R5 error clear after reset", int'(seg_error), 0);
    chk(!in_ready, "R8 ready low while idle", int'(in_ready), 0);
    for (int v = 0; v < NVEC; v++) run_seg(v);
    // directed: a good segment right after a refused one clears the error
    run_seg(0);
    // directed: idle input activity is ignored
    in_valid = 1'b1; in_data = 8'h5A;
    obs_n = 0;
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    chk(obs_n == 0, "R8 no writes from idle stream", obs_n, 0);
    summary();
    $finish;
  end
endmodule